// File: doc/BRIEF.md
# Two-Level Decoded Arithmetic/Logic Unit

This block is the execution arithmetic unit of a small single-cycle load/store processor. It has two parts. The first is a second-level operation decoder. It takes a 2-bit operation class from the main instruction decoder and the 6-bit function field of a register-format instruction, and it turns them into a 4-bit operation code. The second part is a combinational 32-bit datapath that applies that code to two operands. It returns the result and a flag that is high when the result is all zeros.

The operation class chooses what the function field means. Memory accesses force an add, which forms the address. Branches force a subtract, and the zero flag then tells whether the two operands are equal. Register-format instructions hand the choice to the function field. The datapath also carries a NOR operation, which is selected only by its operation code. There is no clock and no stored state: every output settles from the current inputs.

Top module: `alu_unit`

## Requirements
- R1: With operation class 00, op_code is 0010 (add) for every function field value.
- R2: With operation class 01, op_code is 0110 (subtract) for every function field value.
- R3: With operation class 10, function 100000 gives 0010 (add), 100010 gives 0110 (subtract), 100100 gives 0000 (AND), 100101 gives 0001 (OR), and 101010 gives 0111 (set-on-less-than).
- R4: With operation class 10 and function 000000, op_code is 0011 and the result is opnd_b shifted left logically by opnd_a[4:0], with zeros filled in from the right.
- R5: Code 0000 yields the bitwise AND of the operands, 0001 yields the bitwise OR, and 1100 yields the bitwise NOR.
- R6: Code 0010 yields opnd_a + opnd_b and code 0110 yields opnd_a - opnd_b, both modulo 2^32 with no trap.
- R7: Code 0111 yields 1 when opnd_a is less than opnd_b as a two's-complement signed number and 0 otherwise, with bits 31:1 always zero.
- R8: zero is 1 exactly when all 32 bits of result are 0.
- R9: Operation class 11, and any function value under class 10 not listed in R3 or R4, give op_code 0010 (add).
- R10: Only opnd_a[4:0] affects a shift; opnd_a[31:5] have no effect on the shifted result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_class | input | 2 | Operation class from the main decoder |
| funct | input | 6 | Function field of the instruction |
| opnd_a | input | 32 | First operand; also the shift amount |
| opnd_b | input | 32 | Second operand; also the value shifted |
| op_code | output | 4 | Decoded 4-bit operation code |
| result | output | 32 | Datapath result |
| zero | output | 1 | High when result is all zeros |

## Verification
The embedded checks are immediate and combinational. They assume that op_class, funct and both operands hold known 0/1 values, so each check is guarded to skip while any input is unknown. The bench never leaves an input undriven. It applies every class and function pair against a fixed set of operand patterns: equal values, signed extremes, sign-opposed pairs, and shift amounts whose upper bits are set. Every input therefore stays fully known. The NOR path cannot be reached through the decoder, so the bench drives it directly on a second datapath instance.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int unsigned ALU_W   = 32;
    localparam int unsigned FUNCT_W = 6;
    localparam int unsigned OP_W    = 4;

    typedef enum logic [OP_W-1:0] {
        OP_AND = 4'b0000,
        OP_OR  = 4'b0001,
        OP_ADD = 4'b0010,
        OP_SLL = 4'b0011,
        OP_SUB = 4'b0110,
        OP_SLT = 4'b0111,
        OP_NOR = 4'b1100
    } alu_op_e;

    typedef enum logic [1:0] {
        CLS_MEM    = 2'b00,
        CLS_BRANCH = 2'b01,
        CLS_REG    = 2'b10,
        CLS_SPARE  = 2'b11
    } op_class_e;

    localparam logic [FUNCT_W-1:0] FN_SLL = 6'b000000;
    localparam logic [FUNCT_W-1:0] FN_ADD = 6'b100000;
    localparam logic [FUNCT_W-1:0] FN_SUB = 6'b100010;
    localparam logic [FUNCT_W-1:0] FN_AND = 6'b100100;
    localparam logic [FUNCT_W-1:0] FN_OR  = 6'b100101;
    localparam logic [FUNCT_W-1:0] FN_SLT = 6'b101010;

    // Register-format function field mapping; unknown values fall back to add.
    function automatic alu_op_e map_funct(input logic [FUNCT_W-1:0] fn);
        alu_op_e op;
        unique case (fn)
            FN_SLL:  op = OP_SLL;
            FN_ADD:  op = OP_ADD;
            FN_SUB:  op = OP_SUB;
            FN_AND:  op = OP_AND;
            FN_OR:   op = OP_OR;
            FN_SLT:  op = OP_SLT;
            default: op = OP_ADD;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
    import alu_pkg::*;
(
    input  logic [1:0]         op_class,
    input  logic [FUNCT_W-1:0] funct,
    output alu_op_e            op
);

    op_class_e cls;
    assign cls = op_class_e'(op_class);

    always_comb begin
        unique case (cls)
            CLS_MEM:    op = OP_ADD;
            CLS_BRANCH: op = OP_SUB;
            CLS_REG:    op = map_funct(funct);
            default:    op = OP_ADD;
        endcase
    end

    always_comb begin
        if (!$isunknown({op_class, funct})) begin
            // R9: the decoder never emits NOR or an unassigned code
            a_r9_code_legal: assert (op inside {OP_AND, OP_OR, OP_ADD, OP_SLL, OP_SUB, OP_SLT})
                else $error("decoder produced illegal code %b", op);
            // R1/R2: forced classes ignore the function field
            a_r1_mem_class_add: assert (op_class != 2'b00 || op == OP_ADD)
                else $error("memory class did not give add");
            a_r2_branch_class_sub: assert (op_class != 2'b01 || op == OP_SUB)
                else $error("branch class did not give subtract");
        end
    end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
    import alu_pkg::*;
#(
    parameter int unsigned WIDTH = ALU_W
) (
    input  logic [OP_W-1:0]  op_sel,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] y
);

    localparam int unsigned SHAMT_W = $clog2(WIDTH);

    logic [SHAMT_W-1:0] shamt;
    logic [WIDTH-1:0]   sum;
    logic [WIDTH-1:0]   diff;
    logic               lt_signed;

    assign shamt     = a[SHAMT_W-1:0];
    assign sum       = a + b;
    assign diff      = a - b;
    assign lt_signed = $signed(a) < $signed(b);

    always_comb begin
        case (op_sel)
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_NOR:  y = ~(a | b);
            OP_ADD:  y = sum;
            OP_SUB:  y = diff;
            OP_SLT:  y = {{(WIDTH-1){1'b0}}, lt_signed};
            OP_SLL:  y = b << shamt;
            default: y = '0;
        endcase
    end

    always_comb begin
        if (!$isunknown({op_sel, a, b})) begin
            // R7: set-on-less-than only ever drives bit 0
            a_r7_slt_upper_clear: assert (op_sel != OP_SLT || y[WIDTH-1:1] == '0)
                else $error("slt upper bits set");
            // R4: a zero shift amount passes the value unchanged
            a_r4_shift_by_zero: assert (op_sel != OP_SLL || shamt != '0 || y == b)
                else $error("shift by zero altered value");
            // R6: add and subtract are inverses of each other
            a_r6_sub_inverts_add: assert (diff + b == a)
                else $error("subtract does not invert add");
        end
    end

endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] value,
    output logic             is_zero
);

    assign is_zero = ~|value;

endmodule

// File: rtl/alu_unit.sv
module alu_unit
    import alu_pkg::*;
(
    input  logic [1:0]       op_class,
    input  logic [5:0]       funct,
    input  logic [31:0]      opnd_a,
    input  logic [31:0]      opnd_b,
    output logic [3:0]       op_code,
    output logic [31:0]      result,
    output logic             zero
);

    alu_op_e op;

    alu_op_decode u_decode (
        .op_class (op_class),
        .funct    (funct),
        .op       (op)
    );

    assign op_code = op;

    alu_datapath #(.WIDTH(ALU_W)) u_datapath (
        .op_sel (op_code),
        .a      (opnd_a),
        .b      (opnd_b),
        .y      (result)
    );

    alu_zero_detect #(.WIDTH(ALU_W)) u_zero (
        .value   (result),
        .is_zero (zero)
    );

    always_comb begin
        if (!$isunknown({op_class, funct, opnd_a, opnd_b})) begin
            // R8: a set zero flag implies a cleared result, and a cleared result sets it
            a_r8_zero_consistent: assert ((zero && result == '0) || (!zero && result != '0))
                else $error("zero flag disagrees with result");
            // R2/R8: branch class flags equality of the operands
            a_r8_branch_equal: assert (op_class != 2'b01 || zero == (opnd_a == opnd_b))
                else $error("branch compare flag wrong");
        end
    end

endmodule

// File: tb/tb_alu_unit.sv
`timescale 1ns/1ps
module tb_alu_unit;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [1:0]  op_class;
    logic [5:0]  funct;
    logic [31:0] opnd_a, opnd_b;
    logic [3:0]  op_code;
    logic [31:0] result;
    logic        zero;

    logic [3:0]  core_op;
    logic [31:0] core_y;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    alu_unit dut (
        .op_class (op_class),
        .funct    (funct),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .op_code  (op_code),
        .result   (result),
        .zero     (zero)
    );

    alu_datapath #(.WIDTH(32)) core (
        .op_sel (core_op),
        .a      (opnd_a),
        .b      (opnd_b),
        .y      (core_y)
    );

    function automatic logic [3:0] exp_code(input logic [1:0] c, input logic [5:0] f);
        if (c == 2'b00) return 4'b0010;
        if (c == 2'b01) return 4'b0110;
        if (c == 2'b11) return 4'b0010;
        case (f)
            6'b000000: return 4'b0011;
            6'b100000: return 4'b0010;
            6'b100010: return 4'b0110;
            6'b100100: return 4'b0000;
            6'b100101: return 4'b0001;
            6'b101010: return 4'b0111;
            default:   return 4'b0010;
        endcase
    endfunction

    function automatic logic [31:0] exp_result(input logic [3:0] op,
                                               input logic [31:0] a, input logic [31:0] b);
        logic [31:0] r;
        case (op)
            4'b0000: return a & b;
            4'b0001: return a | b;
            4'b1100: return ~(a | b);
            4'b0010: return a + b;
            4'b0110: return a - b;
            4'b0111: begin
                // signed compare written via sign bits and unsigned order
                if (a[31] != b[31]) return {31'd0, a[31]};
                return {31'd0, (a < b)};
            end
            4'b0011: begin
                r = b;
                for (int k = 0; k < 32; k++) if (k < int'(a[4:0])) r = {r[30:0], 1'b0};
                return r;
            end
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [31:0] pat_a(input int i);
        case (i)
            0: return 32'h0000_0000;
            1: return 32'h1234_5678;
            2: return 32'h7FFF_FFFF;
            3: return 32'h8000_0000;
            4: return 32'hFFFF_FFFF;
            5: return 32'hFFFF_FFE3;
            6: return 32'h0000_0020;
            7: return 32'h0000_001F;
            default: return 32'h5A5A_A5A5;
        endcase
    endfunction

    function automatic logic [31:0] pat_b(input int i);
        case (i)
            0: return 32'h0000_0000;
            1: return 32'h1234_5678;
            2: return 32'h8000_0000;
            3: return 32'h7FFF_FFFF;
            4: return 32'h0000_0001;
            5: return 32'h0000_0003;
            6: return 32'hDEAD_BEEF;
            7: return 32'h0000_0001;
            default: return 32'hF0F0_0F0F;
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h (class %b funct %b a %h b %h)",
                     req, what, act, exp, op_class, funct, opnd_a, opnd_b);
        end
    endtask

    function automatic string req_for(input logic [1:0] c, input logic [5:0] f);
        if (c == 2'b00) return "R1";
        if (c == 2'b01) return "R2";
        if (c == 2'b11) return "R9";
        if (f == 6'b000000) return "R4";
        if (f inside {6'b100000, 6'b100010, 6'b100100, 6'b100101, 6'b101010}) return "R3";
        return "R9";
    endfunction

    initial begin
        op_class = 2'b00; funct = '0; opnd_a = '0; opnd_b = '0; core_op = 4'b0010;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        // reset-state style check: all-zero inputs give a zero add result
        check("R8", "idle zero flag", {31'd0, zero}, 32'd1);
        check("R1", "idle code", {28'd0, op_code}, 32'h2);

        // full sweep of class x function x operand patterns
        for (int c = 0; c < 4; c++) begin
            for (int f = 0; f < 64; f++) begin
                for (int p = 0; p < 9; p++) begin
                    @(negedge clk);
                    op_class = 2'(c); funct = 6'(f);
                    opnd_a = pat_a(p); opnd_b = pat_b(p);
                    #1;
                    begin
                        logic [3:0]  ec;
                        logic [31:0] er;
                        ec = exp_code(op_class, funct);
                        er = exp_result(ec, opnd_a, opnd_b);
                        check(req_for(op_class, funct), "op_code", {28'd0, op_code}, {28'd0, ec});
                        case (ec)
                            4'b0111: check("R7", "slt result", result, er);
                            4'b0011: check("R4", "shift result", result, er);
                            4'b0000, 4'b0001: check("R5", "logic result", result, er);
                            default: check("R6", "arith result", result, er);
                        endcase
                        check("R8", "zero flag", {31'd0, zero}, {31'd0, (er == 32'd0)});
                    end
                end
            end
        end

        // R10: upper bits of the shift amount have no effect
        for (int p = 0; p < 9; p++) begin
            @(negedge clk);
            op_class = 2'b10; funct = 6'b000000;
            opnd_a = 32'hABCD_E000 | 32'(p * 3); opnd_b = pat_b(p) | 32'h1;
            #1;
            check("R10", "shift ignores a[31:5]", result, opnd_b << (p * 3));
        end

        // R7 corner: signed vs unsigned order disagree
        @(negedge clk);
        op_class = 2'b10; funct = 6'b101010; opnd_a = 32'hFFFF_FFFF; opnd_b = 32'h0000_0001;
        #1; check("R7", "-1 < 1", result, 32'd1);
        @(negedge clk);
        opnd_a = 32'h0000_0001; opnd_b = 32'hFFFF_FFFF;
        #1; check("R7", "1 < -1", result, 32'd0);

        // R6 corner: wrap-around
        @(negedge clk);
        op_class = 2'b00; opnd_a = 32'hFFFF_FFFF; opnd_b = 32'h0000_0001;
        #1; check("R6", "add wrap", result, 32'd0);
        check("R8", "wrap zero", {31'd0, zero}, 32'd1);

        // R5: NOR and logic codes via direct datapath selection
        for (int p = 0; p < 9; p++) begin
            @(negedge clk);
            opnd_a = pat_a(p); opnd_b = pat_b(p);
            core_op = 4'b1100;
            #1; check("R5", "nor", core_y, ~(pat_a(p) | pat_b(p)));
            @(negedge clk); core_op = 4'b0000;
            #1; check("R5", "and", core_y, pat_a(p) & pat_b(p));
            @(negedge clk); core_op = 4'b0001;
            #1; check("R5", "or", core_y, pat_a(p) | pat_b(p));
        end

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule